// File: doc/BRIEF.md
# Mode-Selectable Direct-Mapped Data Cache

This block is a direct-mapped first-level data cache that sits between a processor load/store port and a single-word memory port. Each line holds one 32-bit word together with its tag, a valid bit and a dirty bit. Two run-time control inputs select the policy. The cache can be switched off, in which case no new lines are filled. It can write stores straight through to memory. It can also hold stores locally as dirty lines and write them out only on eviction. In write-back mode a store miss installs the line directly, because a line is exactly one word and needs no fill.

Two maintenance commands operate on the whole array. One drops every line and discards any dirty data. The other walks the lines in index order, writes each dirty word to memory, and invalidates every line as it passes. Each command ends with a one-cycle completion pulse. The processor side holds a request until it receives a one-cycle ready pulse. The memory side holds a request until it receives a one-cycle acknowledge.

Top module: `modal_dcache`

## Requirements
- R1: In write-back mode (cacheOff=0, storeHold=1), a store that hits, or a store that misses on a clean or empty line, writes only the cache line and marks it dirty. Memory is not written until that line is evicted or flushed, and later loads of that word hit without a memory read.
- R2: The mode is decoded from two inputs. With cacheOff=1 the cache is disabled regardless of storeHold. With cacheOff=0 and storeHold=0 it writes through. With cacheOff=0 and storeHold=1 it writes back.
- R3: In write-through mode every store produces one memory write of that word. Loads that hit are served without a memory read.
- R4: In disabled mode load misses are read from memory without filling a line, and every store goes to memory. Loads that hit an already valid line are still served from the cache, and a store that hits also updates the line.
- R5: A load miss (in a caching mode), or a write-back-mode store miss, whose line holds valid dirty data writes that victim word to its own address before the new line is used. The memory port keeps request, address and direction stable until the acknowledge.
- R6: The invalidate command clears every line and writes nothing to memory. It ends with one flushDone pulse, and a later load reads memory.
- R7: The flush command writes every dirty line to memory and leaves every line invalid. It ends with a flushDone pulse exactly one cycle long.
- R8: cpuReady stays low from the cycle a flush or invalidate command is taken until its flushDone pulse. A request held during that time is served after the pulse.
- R9: A word access whose address bits [1:0] are not 00 completes with cpuErr high together with cpuReady. It makes no memory request and changes no line.
- R10: After reset cpuReady, memReq and flushDone are low and every line is invalid, so the first load misses.
- R11: A load returns the most recent value stored to that address, whether it hits or comes from memory. cpuReady is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheOff | input | 1 | 1 disables caching (no allocation) |
| storeHold | input | 1 | With cacheOff=0: 1 write-back, 0 write-through |
| cmdInval | input | 1 | Invalidate all lines, no write-back (sampled when idle) |
| cmdFlush | input | 1 | Write back dirty lines, then invalidate (sampled when idle, wins over cmdInval) |
| flushDone | output | 1 | One-cycle pulse when a maintenance command finishes |
| cpuReq | input | 1 | Access request, held until cpuReady |
| cpuWe | input | 1 | 1 store, 0 load |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuErr | output | 1 | Misaligned access flag, valid with cpuReady |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | 1 memory write, 0 memory read |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle memory acknowledge |

## Verification
The bench builds the cache with ADDR_W=8 and LINES=16. This leaves a 2-bit tag and a 64-word address space, so a memory model of 64 words covers every address. Every index can then be driven into conflict by four distinct tags. Full sweeps over all 64 words in each mode become short runs, and so do dirty evictions, flushes of a fully dirty array and uncached reads. Expected memory contents and load values are computed from a shadow copy of what the processor last stored.

// File: rtl/modal_dcache_pkg.sv
package modal_dcache_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_WBACK, S_MEMRD, S_MEMWR, S_RESP,
    S_FLSCAN, S_FLWR, S_FDONE
  } ctl_state_e;

  typedef enum logic [1:0] {
    MA_REQ, MA_VICTIM, MA_FLUSH
  } mem_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     lineFromCpu;
    logic     lineDirty;
    logic     lineFromMem;
    logic     rdFromLine;
    logic     rdFromMem;
    logic     clearAll;
    logic     clearFlushLine;
    logic     flIdxClr;
    logic     flIdxInc;
    mem_sel_e memSel;
  } dp_strobe_t;

endpackage

// File: rtl/modal_dcache_datapath.sv
module modal_dcache_datapath
  import modal_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  input  logic [31:0]       memRdata,
  output logic [31:0]       cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              hit,
  output logic              victimDirty,
  output logic              misaligned,
  output logic              flLineDirty,
  output logic              flLast
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [LINES-1:0] validQ, dirtyQ;
  logic [TAG_W-1:0] tagQ  [LINES];
  logic [31:0]      dataQ [LINES];

  logic [ADDR_W-1:0] reqAddr;
  logic [31:0]       reqWdata;
  logic [IDX_W-1:0]  flIdx;

  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;

  assign reqIdx = reqAddr[IDX_W+1:2];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W+2];

  assign misaligned  = reqAddr[1:0] != 2'b00;
  assign hit         = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign victimDirty = validQ[reqIdx] && dirtyQ[reqIdx] && !hit;
  assign flLineDirty = validQ[flIdx] && dirtyQ[flIdx];
  assign flLast      = flIdx == IDX_W'(LINES - 1);

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
    end else if (st.latchReq) begin
      reqAddr  <= cpuAddr;
      reqWdata <= cpuWdata;
    end
  end

  // Flush walk pointer
  always_ff @(posedge clk) begin
    if (!rstN)            flIdx <= '0;
    else if (st.flIdxClr) flIdx <= '0;
    else if (st.flIdxInc) flIdx <= flIdx + 1'b1;
  end

  // Line state bits
  always_ff @(posedge clk) begin
    if (!rstN || st.clearAll) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (st.clearFlushLine) begin
      validQ[flIdx] <= 1'b0;
      dirtyQ[flIdx] <= 1'b0;
    end else if (st.lineFromCpu) begin
      validQ[reqIdx] <= 1'b1;
      dirtyQ[reqIdx] <= st.lineDirty;
    end else if (st.lineFromMem) begin
      validQ[reqIdx] <= 1'b1;
      dirtyQ[reqIdx] <= 1'b0;
    end
  end

  // Tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (st.lineFromCpu) begin
      tagQ[reqIdx]  <= reqTag;
      dataQ[reqIdx] <= reqWdata;
    end else if (st.lineFromMem) begin
      tagQ[reqIdx]  <= reqTag;
      dataQ[reqIdx] <= memRdata;
    end
  end

  // Load result register
  always_ff @(posedge clk) begin
    if (!rstN)              cpuRdata <= '0;
    else if (st.rdFromLine) cpuRdata <= dataQ[reqIdx];
    else if (st.rdFromMem)  cpuRdata <= memRdata;
  end

  // Memory port address and data
  always_comb begin
    case (st.memSel)
      MA_VICTIM: begin
        memAddr  = {tagQ[reqIdx], reqIdx, 2'b00};
        memWdata = dataQ[reqIdx];
      end
      MA_FLUSH: begin
        memAddr  = {tagQ[flIdx], flIdx, 2'b00};
        memWdata = dataQ[flIdx];
      end
      default: begin
        memAddr  = {reqAddr[ADDR_W-1:2], 2'b00};
        memWdata = reqWdata;
      end
    endcase
  end

endmodule

// File: rtl/modal_dcache_control.sv
module modal_dcache_control
  import modal_dcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       cacheOff,
  input  logic       storeHold,
  input  logic       cmdInval,
  input  logic       cmdFlush,
  input  logic       memAck,
  input  logic       hit,
  input  logic       victimDirty,
  input  logic       misaligned,
  input  logic       flLineDirty,
  input  logic       flLast,
  output dp_strobe_t st,
  output logic       cpuReady,
  output logic       cpuErr,
  output logic       memReq,
  output logic       memWe,
  output logic       flushDone,
  output logic       flushBusy
);

  ctl_state_e state, nxt;
  logic weQ, offQ, wbQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      weQ   <= 1'b0;
      offQ  <= 1'b0;
      wbQ   <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (st.latchReq) begin
        weQ  <= cpuWe;
        offQ <= cacheOff;
        wbQ  <= !cacheOff && storeHold;
        errQ <= 1'b0;
      end else if (state == S_LOOK) begin
        errQ <= misaligned;
      end
    end
  end

  always_comb begin
    nxt = state;
    st  = '0;
    case (state)
      S_IDLE: begin
        if (cmdFlush) begin
          st.flIdxClr = 1'b1;
          nxt = S_FLSCAN;
        end else if (cmdInval) begin
          st.clearAll = 1'b1;
          nxt = S_FDONE;
        end else if (cpuReq) begin
          st.latchReq = 1'b1;
          nxt = S_LOOK;
        end
      end
      S_LOOK: begin
        if (misaligned) begin
          nxt = S_RESP;
        end else if (!weQ) begin
          if (hit) begin
            st.rdFromLine = 1'b1;
            nxt = S_RESP;
          end else if (!offQ && victimDirty) begin
            nxt = S_WBACK;
          end else begin
            nxt = S_MEMRD;
          end
        end else if (hit) begin
          st.lineFromCpu = 1'b1;
          st.lineDirty   = wbQ;
          nxt = wbQ ? S_RESP : S_MEMWR;
        end else if (!wbQ) begin
          nxt = S_MEMWR;
        end else if (victimDirty) begin
          nxt = S_WBACK;
        end else begin
          st.lineFromCpu = 1'b1;
          st.lineDirty   = 1'b1;
          nxt = S_RESP;
        end
      end
      S_WBACK: begin
        st.memSel = MA_VICTIM;
        if (memAck) begin
          if (weQ) begin
            st.lineFromCpu = 1'b1;
            st.lineDirty   = 1'b1;
            nxt = S_RESP;
          end else begin
            nxt = S_MEMRD;
          end
        end
      end
      S_MEMRD: begin
        if (memAck) begin
          st.rdFromMem   = 1'b1;
          st.lineFromMem = !offQ;
          nxt = S_RESP;
        end
      end
      S_MEMWR: begin
        if (memAck) nxt = S_RESP;
      end
      S_RESP: nxt = S_IDLE;
      S_FLSCAN: begin
        st.memSel = MA_FLUSH;
        if (flLineDirty) begin
          nxt = S_FLWR;
        end else begin
          st.clearFlushLine = 1'b1;
          if (flLast) nxt = S_FDONE;
          else        st.flIdxInc = 1'b1;
        end
      end
      S_FLWR: begin
        st.memSel = MA_FLUSH;
        if (memAck) begin
          st.clearFlushLine = 1'b1;
          if (flLast) begin
            nxt = S_FDONE;
          end else begin
            st.flIdxInc = 1'b1;
            nxt = S_FLSCAN;
          end
        end
      end
      S_FDONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign cpuReady  = state == S_RESP;
  assign cpuErr    = cpuReady && errQ;
  assign memReq    = (state == S_WBACK) || (state == S_MEMRD) ||
                     (state == S_MEMWR) || (state == S_FLWR);
  assign memWe     = memReq && (state != S_MEMRD);
  assign flushDone = state == S_FDONE;
  assign flushBusy = (state == S_FLSCAN) || (state == S_FLWR);

endmodule

// File: rtl/modal_dcache.sv
module modal_dcache
  import modal_dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheOff,
  input  logic              storeHold,
  input  logic              cmdInval,
  input  logic              cmdFlush,
  output logic              flushDone,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuReady,
  output logic              cpuErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);

  dp_strobe_t st;
  logic hit, victimDirty, misaligned, flLineDirty, flLast, flushBusy;

  modal_dcache_control u_ctl (
    .clk, .rstN, .cpuReq, .cpuWe, .cacheOff, .storeHold,
    .cmdInval, .cmdFlush, .memAck, .hit, .victimDirty, .misaligned,
    .flLineDirty, .flLast, .st, .cpuReady, .cpuErr, .memReq, .memWe,
    .flushDone, .flushBusy
  );

  modal_dcache_datapath #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dp (
    .clk, .rstN, .st, .cpuAddr, .cpuWdata, .memRdata, .cpuRdata,
    .memAddr, .memWdata, .hit, .victimDirty, .misaligned,
    .flLineDirty, .flLast
  );

endmodule

// File: rtl/modal_dcache_chk.sv
module modal_dcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              cpuErr,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              flushDone,
  input logic              flushBusy
);

  p_err_with_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> cpuReady && !memReq);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |=> !flushDone);

  p_no_ready_in_walk_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |-> !cpuReady);

  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  p_walk_ends_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushBusy) |-> flushDone);

endmodule

bind modal_dcache modal_dcache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_modal_dcache.sv
module test_modal_dcache;

  localparam int AW = 8;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cacheOff = 1'b0, storeHold = 1'b0, cmdInval = 1'b0, cmdFlush = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic cpuReady, cpuErr, flushDone;
  logic memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;

  logic [31:0] mem [NW];
  logic [31:0] shadow [NW];
  int memWrCnt = 0, memRdCnt = 0;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  modal_dcache #(.ADDR_W(AW), .LINES(16)) i_modal_dcache (
    .clk, .rstN, .cacheOff, .storeHold, .cmdInval, .cmdFlush, .flushDone,
    .cpuReq, .cpuWe, .cpuAddr, .cpuWdata, .cpuRdata, .cpuReady, .cpuErr,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck
  );

  // Memory model: acknowledge one cycle after a request
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        if (memWe) begin
          mem[memAddr[7:2]] <= memWdata;
          memWrCnt <= memWrCnt + 1;
        end else begin
          memRdata <= mem[memAddr[7:2]];
          memRdCnt <= memRdCnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] pat(int i, int k);
    return 32'h5A00_0000 + 32'(k << 16) + 32'(i * 257);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    do @(negedge clk); while (!cpuReady);
    rd = cpuRdata; er = cpuErr;
    cpuReq = 1'b0;
    if (we && !er) shadow[addr[7:2]] = wd;
  endtask

  task automatic pulse_cmd(input bit flush);
    @(negedge clk);
    if (flush) cmdFlush = 1'b1; else cmdInval = 1'b1;
    @(negedge clk);
    cmdFlush = 1'b0; cmdInval = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int c0, w0, doneCnt, early, bad;
    for (int i = 0; i < NW; i++) begin mem[i] = pat(i, 0); shadow[i] = pat(i, 0); end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ready", {31'd0, cpuReady}, 32'd0);
    check("R10 memReq", {31'd0, memReq}, 32'd0);
    check("R10 flushDone", {31'd0, flushDone}, 32'd0);
    c0 = memRdCnt;
    access(1'b0, 8'h00, 32'h0, rd, er);
    check("R10 first load misses", 32'(memRdCnt - c0), 32'd1);
    check("R11 reset load data", rd, pat(0, 0));

    // Write-through sweep (R2, R3)
    for (int i = 0; i < NW; i++) begin
      w0 = memWrCnt;
      access(1'b1, 8'(i * 4), pat(i, 1), rd, er);
      check("R3 store reaches memory", mem[i], pat(i, 1));
      check("R2 write-through one write", 32'(memWrCnt - w0), 32'd1);
    end
    for (int i = 0; i < NW; i++) begin
      access(1'b0, 8'(i * 4), 32'h0, rd, er);
      check("R11 load after write-through", rd, shadow[i]);
    end
    c0 = memRdCnt;
    for (int i = 48; i < NW; i++) begin
      access(1'b0, 8'(i * 4), 32'h0, rd, er);
      check("R3 hit data", rd, shadow[i]);
    end
    check("R3 hits need no memory read", 32'(memRdCnt - c0), 32'd0);

    // Write-back (R1, R5)
    storeHold = 1'b1;
    w0 = memWrCnt;
    for (int i = 48; i < NW; i++) access(1'b1, 8'(i * 4), pat(i, 2), rd, er);
    check("R1 no memory writes", 32'(memWrCnt - w0), 32'd0);
    check("R1 memory keeps old word", mem[48], pat(48, 1));
    c0 = memRdCnt;
    for (int i = 48; i < NW; i++) begin
      access(1'b0, 8'(i * 4), 32'h0, rd, er);
      check("R11 load of dirty line", rd, shadow[i]);
    end
    check("R1 dirty loads hit", 32'(memRdCnt - c0), 32'd0);
    access(1'b1, 8'h00, pat(0, 3), rd, er);
    check("R5 store miss evicts victim", mem[48], pat(48, 2));
    check("R1 new store held in cache", mem[0], pat(0, 1));
    access(1'b0, 8'(17 * 4), 32'h0, rd, er);
    check("R5 load miss evicts victim", mem[49], pat(49, 2));
    check("R11 load after eviction", rd, shadow[17]);

    // Flush with a held request (R7, R8)
    @(negedge clk);
    cmdFlush = 1'b1; cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 8'(50 * 4);
    doneCnt = 0; early = 0;
    @(negedge clk);
    cmdFlush = 1'b0;
    for (int n = 0; n < 500; n++) begin
      if (flushDone) doneCnt++;
      if (cpuReady) begin
        if (doneCnt == 0) early = 1;
        break;
      end
      @(negedge clk);
    end
    rd = cpuRdata;
    cpuReq = 1'b0;
    check("R8 no ready during flush", 32'(early), 32'd0);
    check("R7 single done pulse", 32'(doneCnt), 32'd1);
    check("R8 held load served after", rd, shadow[50]);
    bad = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== shadow[i]) bad++;
    check("R7 memory matches after flush", 32'(bad), 32'd0);
    c0 = memRdCnt;
    access(1'b0, 8'(51 * 4), 32'h0, rd, er);
    check("R7 lines invalid after flush", 32'(memRdCnt - c0), 32'd1);

    // Invalidate (R6)
    access(1'b1, 8'(37 * 4), pat(37, 4), rd, er);
    w0 = memWrCnt;
    pulse_cmd(1'b0);
    check("R6 done pulse", {31'd0, flushDone}, 32'd1);
    @(negedge clk);
    check("R6 no write-back", 32'(memWrCnt - w0), 32'd0);
    shadow[37] = mem[37];
    access(1'b0, 8'(37 * 4), 32'h0, rd, er);
    check("R6 dirty data dropped", rd, pat(37, 1));

    // Disabled (R4, R2)
    access(1'b0, 8'(7 * 4), 32'h0, rd, er);
    cacheOff = 1'b1;
    mem[7] = ~mem[7];
    access(1'b0, 8'(7 * 4), 32'h0, rd, er);
    check("R4 hit served from line", rd, shadow[7]);
    access(1'b0, 8'(24 * 4), 32'h0, rd, er);
    check("R4 uncached load", rd, mem[24]);
    mem[24] = mem[24] ^ 32'h0000_FFFF;
    shadow[24] = mem[24];
    access(1'b0, 8'(24 * 4), 32'h0, rd, er);
    check("R4 no allocation", rd, shadow[24]);
    access(1'b1, 8'(24 * 4), pat(24, 5), rd, er);
    check("R2 disabled overrides storeHold", mem[24], pat(24, 5));
    access(1'b1, 8'(7 * 4), pat(7, 5), rd, er);
    check("R4 store hit goes to memory", mem[7], pat(7, 5));
    cacheOff = 1'b0;
    c0 = memRdCnt;
    access(1'b0, 8'(7 * 4), 32'h0, rd, er);
    check("R4 store hit updated line", rd, pat(7, 5));
    check("R4 line still hits", 32'(memRdCnt - c0), 32'd0);

    // Misaligned (R9)
    c0 = memRdCnt + memWrCnt;
    access(1'b1, 8'h09, 32'hDEAD_BEEF, rd, er);
    check("R9 store error flag", {31'd0, er}, 32'd1);
    access(1'b0, 8'h0E, 32'h0, rd, er);
    check("R9 load error flag", {31'd0, er}, 32'd1);
    check("R9 no memory traffic", 32'(memRdCnt + memWrCnt - c0), 32'd0);
    access(1'b0, 8'h08, 32'h0, rd, er);
    check("R9 word unchanged", rd, shadow[2]);
    check("R9 aligned access no error", {31'd0, er}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule